// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block decides when the core of a small microcontroller may leave reset. It sees the start of a supply event as a power-on or brown-out pulse. Once that pulse ends, it runs up to two delay phases in a fixed order. The first is a power-up delay counted in ticks of a slow timebase. The second is an oscillator settling count, counted in cycles of the main clock. When both are done, it drops the core reset.

Whether each phase runs depends on two inputs. A power-up-timer enable controls the first phase. The clock-mode selection controls the second: only crystal-type modes need a settling count. A wake from sleep needs only the settling count, and only in crystal-type modes.

The external active-low reset pin acts only on the output. It keeps the core in reset but does not pause or restart the delays. If the delays have already run out, releasing the pin frees the core at the next clock edge. A phase code is output so that the active phase can be observed.

Top module: `rto_top`

## Requirements
- R1: While the power-on pulse or the brown-out pulse is high at a clock edge, the phase code after that edge is 1 (hold) and `core_rst_o` is 1.
- R2: If the timer enable is 1, the phase goes from hold to 2 (power-up delay) at the first edge where both pulses are low. It stays there until `PWRT_TICKS` slow ticks have been sampled in that phase.
- R3: In crystal-type modes (`clk_mode_i` codes 0, 1 and 2), the phase after the power-up delay is 3 (settling). The settling phase lasts exactly `OST_CYCLES` clock cycles before the phase becomes 0 (run).
- R4: In the other modes (codes 3 to 7), the settling phase never runs after a pulse. The phase moves straight to run when the power-up delay ends.
- R5: With the timer enable at 0 and a non-crystal mode, the phase is run and `core_rst_o` is 0 at the first clock edge after the pulse ends.
- R6: A wake request sampled in the run phase starts a settling phase of `OST_CYCLES` cycles in crystal-type modes, with reset held. In other modes it has no effect, and the phase stays run with reset low. A wake request is ignored in any other phase.
- R7: A brown-out pulse causes the same sequence as a power-on pulse: hold, then the power-up delay if it is enabled, then settling in crystal-type modes.
- R8: While `mclr_n_i` is low, `core_rst_o` is 1 one edge later, and the phases keep advancing. When the pin is high and the phase is run, `core_rst_o` is 0 after the next edge.
- R9: A power-on or brown-out pulse during any phase returns the phase to hold, and the power-up delay later starts again from zero.
- R10: `core_rst_o` is a register. It is 1 whenever the phase code is not run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_pulse_i | input | 1 | Power-on detector pulse, active high |
| bor_pulse_i | input | 1 | Brown-out detector pulse, active high |
| wake_req_i | input | 1 | Wake-from-sleep request |
| mclr_n_i | input | 1 | External reset pin, active low, assumed synchronous to clk |
| clk_mode_i | input | 3 | Clock mode; codes 0..2 are crystal-type |
| pwrt_en_i | input | 1 | Power-up delay enable |
| slow_tick_i | input | 1 | One-cycle pulse from the slow timebase |
| core_rst_o | output | 1 | Registered core reset, active high |
| phase_o | output | 2 | 0 run, 1 hold, 2 power-up delay, 3 settling |

## Verification
A wrong phase shows up on `phase_o` at the very next edge. A count that is too short or too long shows up only when its phase ends. It appears as a release edge on `core_rst_o` that is early or late by a whole number of slow ticks or clock cycles. The bench therefore compares both outputs on every cycle against a countdown model. A wrong mode decode looks like a missing settling phase, or one that should not be there. A wrongly gated pin shows up as a release while `mclr_n_i` is still low.

// File: rtl/rto_pkg.sv
package rto_pkg;
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_HOLD = 2'd1,
    PH_PWRT = 2'd2,
    PH_OST  = 2'd3
  } rto_phase_e;
endpackage

// File: rtl/rto_mode_decode.sv
module rto_mode_decode #(
  parameter int MODE_W     = 3,
  parameter int XTAL_MODES = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic              crystal_o
);
  // Crystal-type modes occupy the lowest codes.
  localparam logic [MODE_W-1:0] XTAL_LIMIT = MODE_W'(XTAL_MODES);
  assign crystal_o = (mode_i < XTAL_LIMIT);
endmodule

// File: rtl/rto_tick_counter.sv
module rto_tick_counter #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic run_i,
  input  logic step_i,
  output logic done_o
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // Cleared whenever its phase is not active, so every entry starts at zero.
  always_ff @(posedge clk) begin
    if (!run_i)
      cnt_q <= '0;
    else if (step_i)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && step_i && (cnt_q == LAST);
endmodule

// File: rtl/rto_seq_fsm.sv
module rto_seq_fsm
  import rto_pkg::*;
(
  input  logic       clk,
  input  logic       event_i,
  input  logic       wake_i,
  input  logic       pwrt_en_i,
  input  logic       crystal_i,
  input  logic       pwrt_done_i,
  input  logic       ost_done_i,
  output rto_phase_e phase_q,
  output rto_phase_e phase_d
);
  always_comb begin
    phase_d = phase_q;
    if (event_i) begin
      phase_d = PH_HOLD;
    end else begin
      case (phase_q)
        PH_HOLD: begin
          if (pwrt_en_i)      phase_d = PH_PWRT;
          else if (crystal_i) phase_d = PH_OST;
          else                phase_d = PH_RUN;
        end
        PH_PWRT: if (pwrt_done_i) phase_d = crystal_i ? PH_OST : PH_RUN;
        PH_OST:  if (ost_done_i)  phase_d = PH_RUN;
        PH_RUN:  if (wake_i && crystal_i) phase_d = PH_OST;
        default: phase_d = PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) phase_q <= phase_d;
endmodule

// File: rtl/rto_top.sv
module rto_top
  import rto_pkg::*;
#(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024,
  parameter int MODE_W     = 3,
  parameter int XTAL_MODES = 3
) (
  input  logic              clk,
  input  logic              por_pulse_i,
  input  logic              bor_pulse_i,
  input  logic              wake_req_i,
  input  logic              mclr_n_i,
  input  logic [MODE_W-1:0] clk_mode_i,
  input  logic              pwrt_en_i,
  input  logic              slow_tick_i,
  output logic              core_rst_o,
  output logic [1:0]        phase_o
);
  rto_phase_e phase_q, phase_d;
  logic crystal, pwrt_done, ost_done, any_event;

  assign any_event = por_pulse_i | bor_pulse_i;

  rto_mode_decode #(.MODE_W(MODE_W), .XTAL_MODES(XTAL_MODES)) u_mode (
    .mode_i(clk_mode_i), .crystal_o(crystal));

  rto_tick_counter #(.LIMIT(PWRT_TICKS)) u_pwrt (
    .clk(clk), .run_i(phase_q == PH_PWRT), .step_i(slow_tick_i), .done_o(pwrt_done));

  rto_tick_counter #(.LIMIT(OST_CYCLES)) u_ost (
    .clk(clk), .run_i(phase_q == PH_OST), .step_i(1'b1), .done_o(ost_done));

  rto_seq_fsm u_fsm (
    .clk(clk), .event_i(any_event), .wake_i(wake_req_i), .pwrt_en_i(pwrt_en_i),
    .crystal_i(crystal), .pwrt_done_i(pwrt_done), .ost_done_i(ost_done),
    .phase_q(phase_q), .phase_d(phase_d));

  // The pin gates only the output; the phases keep advancing.
  always_ff @(posedge clk) core_rst_o <= (phase_d != PH_RUN) || !mclr_n_i;

  assign phase_o = phase_q;
endmodule

// File: rtl/rto_checker.sv
module rto_checker #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              por_pulse_i,
  input logic              bor_pulse_i,
  input logic              wake_req_i,
  input logic              mclr_n_i,
  input logic [MODE_W-1:0] clk_mode_i,
  input logic              pwrt_en_i,
  input logic              slow_tick_i,
  input logic              core_rst_o,
  input logic [1:0]        phase_o
);
  logic [1:0] armed;
  initial armed = 2'b00;
  always @(posedge clk) begin
    armed[0] <= armed[0] | por_pulse_i;
    armed[1] <= armed[0];
  end

  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!armed[1])
    (por_pulse_i || bor_pulse_i) |=> (phase_o == 2'd1 && core_rst_o)); // R1
  AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!armed[1])
    (phase_o == 2'd1 && (por_pulse_i || bor_pulse_i)) |=> phase_o == 2'd1); // R2
  AST_PWRT_FROM_HOLD: assert property (@(posedge clk) disable iff (!armed[1])
    (phase_o == 2'd2) |-> ($past(phase_o) == 2'd1 || $past(phase_o) == 2'd2)); // R2
  AST_OST_NEEDS_XTAL: assert property (@(posedge clk) disable iff (!armed[1])
    (phase_o == 2'd3 && $past(phase_o) != 2'd3) |-> ($past(clk_mode_i) < MODE_W'(3))); // R4
  AST_WAKE_NO_XTAL: assert property (@(posedge clk) disable iff (!armed[1])
    (phase_o == 2'd0 && wake_req_i && clk_mode_i >= MODE_W'(3) && !por_pulse_i && !bor_pulse_i)
      |=> phase_o == 2'd0); // R6
  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!armed[1])
    !mclr_n_i |=> core_rst_o); // R8
  AST_RUN_RELEASES: assert property (@(posedge clk) disable iff (!armed[1])
    (phase_o == 2'd0 && $past(mclr_n_i)) |-> !core_rst_o); // R8
  AST_NOT_RUN_RESET: assert property (@(posedge clk) disable iff (!armed[1])
    (phase_o != 2'd0) |-> core_rst_o); // R10
endmodule

bind rto_top rto_checker #(.MODE_W(MODE_W)) chk_i (.*);

// File: tb/rto_top_tb_top.sv
module rto_top_tb_top;
  localparam int PWRT_TICKS = 72;
  localparam int OST_CYCLES = 1024;
  localparam int TICK_DIV   = 8;

  logic clk = 1'b0;
  logic por = 1'b0, bor = 1'b0, wake = 1'b0, mclr_n = 1'b1, pwrt_en = 1'b1, tick = 1'b0;
  logic [2:0] mode = 3'd2;
  logic core_rst;
  logic [1:0] phase;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rto_top dut_i (
    .clk(clk), .por_pulse_i(por), .bor_pulse_i(bor), .wake_req_i(wake),
    .mclr_n_i(mclr_n), .clk_mode_i(mode), .pwrt_en_i(pwrt_en),
    .slow_tick_i(tick), .core_rst_o(core_rst), .phase_o(phase));

  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt = tick_cnt + 1;
    tick = (tick_cnt % TICK_DIV == 0);
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural countdown model, updated on the same edge as the design.
  int m_ph = 1, m_left = 0;
  bit m_valid = 0;
  always @(posedge clk) begin
    bit xt;
    xt = (mode < 3);
    if (por || bor) begin
      m_ph = 1; m_left = 0;
      if (por) m_valid = 1;
    end else if (m_ph == 1) begin
      if (pwrt_en) begin m_ph = 2; m_left = PWRT_TICKS; end
      else if (xt) begin m_ph = 3; m_left = OST_CYCLES; end
      else m_ph = 0;
    end else if (m_ph == 2) begin
      if (tick) m_left--;
      if (m_left == 0) begin
        if (xt) begin m_ph = 3; m_left = OST_CYCLES; end
        else m_ph = 0;
      end
    end else if (m_ph == 3) begin
      m_left--;
      if (m_left == 0) m_ph = 0;
    end else if (wake && xt) begin
      m_ph = 3; m_left = OST_CYCLES;
    end
    if (m_valid) begin
      int exp_rst;
      exp_rst = (m_ph == 0 && mclr_n) ? 0 : 1;
      #1;
      if (phase != 2'(m_ph))
        check(m_ph == 1 ? "R1 phase" : m_ph == 2 ? "R2 phase" : m_ph == 3 ? "R3 phase" : "R4 phase",
              int'(phase), m_ph);
      else n_checks++;
      check(exp_rst == 1 && m_ph != 0 ? "R10 core_rst" : "R8 core_rst", int'(core_rst), exp_rst);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sample();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input bit is_bor, input int n);
    @(negedge clk);
    if (is_bor) bor = 1'b1; else por = 1'b1;
    cyc(n);
    por = 1'b0; bor = 1'b0;
  endtask

  task automatic wait_run(input int limit, output bit saw_ost);
    saw_ost = 0;
    for (int i = 0; i < limit; i++) begin
      sample();
      if (phase == 2'd3) saw_ost = 1;
      if (phase == 2'd0) break;
    end
  endtask

  initial begin
    bit saw;
    int ost_len;
    // R1: reset state while the power-on pulse is high
    mode = 3'd2; pwrt_en = 1'b1;
    @(negedge clk); por = 1'b1;
    sample(); sample();
    check("R1 hold phase", int'(phase), 1);
    check("R1 core_rst", int'(core_rst), 1);
    @(negedge clk); por = 1'b0;
    sample();
    check("R2 delay starts after pulse", int'(phase), 2);
    // R3: crystal mode goes through settling of exact length
    for (int i = 0; i < 2000 && phase != 2'd3; i++) sample();
    check("R3 settling follows delay", int'(phase), 3);
    ost_len = 0;
    while (phase == 2'd3) begin ost_len++; sample(); end
    check("R3 settling length", ost_len, OST_CYCLES);
    check("R3 release", int'(core_rst), 0);

    // R6: wake in crystal mode
    @(negedge clk); mode = 3'd1; wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    check("R6 wake xtal settling", int'(phase), 3);
    check("R6 wake holds reset", int'(core_rst), 1);
    wait_run(OST_CYCLES + 4, saw);
    check("R6 wake returns to run", int'(phase), 0);
    // R6: wake in external-clock mode is ignored
    @(negedge clk); mode = 3'd3; wake = 1'b1;
    cyc(3); wake = 1'b0;
    sample();
    check("R6 wake ignored phase", int'(phase), 0);
    check("R6 wake ignored reset", int'(core_rst), 0);

    // R5: external clock, no delay
    @(negedge clk); pwrt_en = 1'b0; mode = 3'd3;
    pulse(0, 3);
    sample();
    check("R5 immediate release", int'(core_rst), 0);
    check("R5 run phase", int'(phase), 0);

    // R4: RC mode with delay, no settling
    @(negedge clk); pwrt_en = 1'b1; mode = 3'd6;
    pulse(0, 2);
    wait_run(PWRT_TICKS * TICK_DIV + 20, saw);
    check("R4 no settling", int'(saw), 0);
    check("R4 reaches run", int'(phase), 0);

    // R7: brown-out follows the same path
    @(negedge clk); mode = 3'd0;
    pulse(1, 2);
    sample();
    check("R7 delay after brown-out", int'(phase), 2);
    wait_run(PWRT_TICKS * TICK_DIV + OST_CYCLES + 20, saw);
    check("R7 settling after brown-out", int'(saw), 1);

    // R9: restart during settling and during delay
    pulse(0, 1);
    for (int i = 0; i < 2000 && phase != 2'd3; i++) sample();
    cyc(100);
    pulse(1, 1);
    check("R9 restart to hold", int'(phase), 1);
    sample();
    check("R9 delay restarts", int'(phase), 2);
    cyc(40);
    pulse(0, 1);
    check("R9 restart from delay", int'(phase), 1);
    wait_run(PWRT_TICKS * TICK_DIV + OST_CYCLES + 20, saw);

    // R8: pin held low while time-outs expire
    @(negedge clk); mode = 3'd3; pwrt_en = 1'b1; mclr_n = 1'b0;
    pulse(0, 2);
    cyc(PWRT_TICKS * TICK_DIV + 30);
    sample();
    check("R8 timers ran", int'(phase), 0);
    check("R8 pin holds reset", int'(core_rst), 1);
    @(negedge clk); mclr_n = 1'b1;
    sample();
    check("R8 release on pin rise", int'(core_rst), 0);
    cyc(5);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog R1..all actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule